// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog for a chipset management area. Software programs a timeout in ticks, and the block counts that value down at a fixed tick rate. When the count runs out the first time, the block sets a status flag, pulses the system management interrupt (SMI) line if SMI is enabled, reloads itself from the timeout and keeps counting. If it runs out a second time in a row with no reload in between, it records the event in a second status register. It then pulses a reset request, unless a board strap or a reboot-block input holds the reset off.

Software reaches the block through a small 16-bit register port with a 4-bit local address. The port gives access to these registers:

- the live count
- a data-in byte and a data-out byte, whose writes have status and SMI side effects
- two status registers
- two control registers, the first of which holds a halt bit and a lock bit that stays set until reset
- two message bytes
- a watchdog control byte
- the timeout value
- a software interrupt byte

One tick is a parameterised number of clock cycles. The count and timeout fields are a parameterised number of bits wide.

Top module: `wdt_two_stage`

## Requirements
- R1: The timer runs only when the halt bit (control 1 bit 0) is clear and the timeout value is greater than 1. With a timeout of 0 or 1, or with halt set, a reload write or a control 1 write never starts counting, and no expiry occurs.
- R2: While running, the count (address 0) drops by one every TICK_CYCLES clocks. A read of address 0 returns the ticks remaining. An expiry happens TICK_CYCLES×timeout clocks after a start. It sets status 1 bit 0 and restarts the count from the timeout, with the tick phase unchanged.
- R3: Two expiries in a row with no reload write between them set status 2 bit 0 (second timeout) and bit 1 (boot status). The pair counter then returns to zero.
- R4: On a second expiry, if both the strap input and the reboot-block input are low, the block pulses rst_req_o for one cycle and gives no SMI for that expiry. The timer stops and the count reads 0. If either input is high, the second expiry behaves like a first expiry.
- R5: After every expiry that does not cause a reset, smi_o pulses for one cycle, in the clock after the expiry edge, only when smi_en_i is high.
- R6: Any write to address 0 clears the pair counter. If R1's conditions hold, the write restarts the count from the timeout. Otherwise it stores the written value masked to the count width and stops the timer. A register write that starts or stops the timer takes priority over an expiry in the same cycle.
- R7: A write to control 1 (address 5) keeps bits 1:0. If R1's conditions then hold, it restarts from the timeout; otherwise it stops the timer and freezes the count.
- R8: Once the lock bit (control 1 bit 1) is set, software writes cannot clear it. Only reset clears it.
- R9: A write to data-in (address 1) stores the low byte, sets status 1 bit 1 and pulses smi_o in the next cycle, whatever smi_en_i is. A write to data-out (address 2) stores the low byte and sets status 1 bit 2, with no SMI.
- R10: After reset the timeout (address 10) is 4, control 2 (address 6) is 0x0008 and the software interrupt byte (address 11) is 0x03. All other addresses read 0, the timer is stopped and both pulse outputs are low.
- R11: A write to status 1 (address 3) replaces it with the written value masked to 0x0007. A write to status 2 (address 4) replaces it with the written value masked to 0x0003.
- R12: The plain registers read back what was written. Control 2 is 16 bits. Message 1 (address 7), message 2 (address 8), watchdog control (address 9) and the software interrupt byte (address 11) are 8 bits. The timeout is masked to the count width. Addresses 12 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Write strobe, one write per cycle |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i, combinational |
| smi_en_i | input | 1 | Enables SMI on timer expiry |
| hold_strap_i | input | 1 | Strap; high holds off the reset request |
| reboot_block_i | input | 1 | High holds off the reset request |
| smi_o | output | 1 | One-cycle SMI pulse |
| rst_req_o | output | 1 | One-cycle reset request pulse |

## Verification
The assertions check these rules on every cycle:

- the count steps down by exactly one on each tick
- ticks are spaced apart
- the timer never starts with a timeout below 2
- the lock bit never falls
- a second expiry always leaves both status 2 bits set
- a reset request always leaves the timer stopped
- any SMI traces back to either a data-in write or an enabled expiry

Only the bench's scenarios can show the exact expiry cycle for each timeout value, the choice between reset and SMI under each strap and reboot-block setting, and the clearing of the pair counter by a reload. The same holds for the masked stores and the reset contents of every address.

// File: rtl/wdt_pkg.sv
// Package: shared address map, bit positions, masks and reset values for
// the two-stage watchdog. Assumes a 16-bit register port.
package wdt_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_COUNT   = 4'd0,
        A_DIN     = 4'd1,
        A_DOUT    = 4'd2,
        A_STAT1   = 4'd3,
        A_STAT2   = 4'd4,
        A_CTRL1   = 4'd5,
        A_CTRL2   = 4'd6,
        A_MSG1    = 4'd7,
        A_MSG2    = 4'd8,
        A_WDCTL   = 4'd9,
        A_TIMEOUT = 4'd10,
        A_SWIRQ   = 4'd11
    } reg_addr_e;

    // status 1 bits
    localparam int S1_EXPIRED = 0;
    localparam int S1_SWSMI   = 1;
    localparam int S1_DOUT    = 2;
    // status 2 bits
    localparam int S2_SECOND  = 0;
    localparam int S2_BOOT    = 1;
    // control 1 bits
    localparam int C1_HALT    = 0;
    localparam int C1_LOCK    = 1;

    localparam logic [REG_W-1:0] STAT1_MASK = 16'h0007;
    localparam logic [REG_W-1:0] STAT2_MASK = 16'h0003;
    localparam logic [REG_W-1:0] CTRL1_MASK = 16'h0003;

    localparam logic [REG_W-1:0] CTRL2_RST   = 16'h0008;
    localparam logic [7:0]       SWIRQ_RST   = 8'h03;
    localparam int               TIMEOUT_RST = 4;

endpackage

// File: rtl/wdt_prescaler.sv
// Module: wdt_prescaler
// Divides the clock into a one-cycle tick strobe every TICK_CYCLES clocks
// while the timer runs. A clear restarts the phase. When the timer is idle
// the divider is held at zero. Assumes TICK_CYCLES >= 1.
module wdt_prescaler #(
    parameter int TICK_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] div_q;

    // divider: free-running modulo TICK_CYCLES while running
    always_ff @(posedge clk) begin
        if (!rst_n)                 div_q <= '0;
        else if (clear_i || !run_i) div_q <= '0;
        else if (div_q == LAST)     div_q <= '0;
        else                        div_q <= div_q + 1'b1;
    end

    assign tick_o = run_i && (div_q == LAST);

    generate
        if (TICK_CYCLES > 1) begin : g_gap_chk
            a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/wdt_countdown.sv
// Module: wdt_countdown
// Holds the single count register, the run flag and the expiry-pair flag.
// Register commands (start, store, stop) beat an expiry in the same cycle.
// Assumes at most one command per cycle.
module wdt_countdown #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             store_i,
    input  logic [CNT_W-1:0] store_val_i,
    input  logic             seq_clr_i,
    input  logic [CNT_W-1:0] timeout_i,
    input  logic             reset_allowed_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             expire_o,
    output logic             second_o,
    output logic             fire_reset_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             armed_q;
    logic             cmd_busy;

    assign cmd_busy     = start_i || stop_i || store_i;
    assign expire_o     = run_q && tick_i && (cnt_q <= CNT_W'(1)) && !cmd_busy;
    assign second_o     = expire_o && armed_q;
    assign fire_reset_o = second_o && reset_allowed_i;
    assign cnt_o        = cnt_q;
    assign run_o        = run_q;

    // count and run state: commands, then reset expiry, expiry, tick step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start_i) begin
            cnt_q <= timeout_i;
            run_q <= 1'b1;
        end else if (store_i) begin
            cnt_q <= store_val_i;
            run_q <= 1'b0;
        end else if (stop_i) begin
            run_q <= 1'b0;
        end else if (fire_reset_o) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (expire_o) begin
            cnt_q <= timeout_i;
        end else if (run_q && tick_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // pair flag: toggles on each expiry, cleared by a count-register write
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (seq_clr_i) armed_q <= 1'b0;
        else if (expire_o)  armed_q <= !armed_q;
    end

    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_i && cnt_q > CNT_W'(1) && !cmd_busy)
        |=> cnt_q == $past(cnt_q) - 1'b1);

    a_r1_start_needs_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> timeout_i > CNT_W'(1));
endmodule

// File: rtl/wdt_regs.sv
// Module: wdt_regs
// Register file and write decode. Turns writes into timer commands and
// merges expiry events into the status registers (events win over a
// same-cycle status write). Assumes one access per cycle, CNT_W <= 16.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              expire_i,
    input  logic              second_i,
    output logic [CNT_W-1:0]  timeout_o,
    output logic              start_o,
    output logic              stop_o,
    output logic              store_o,
    output logic [CNT_W-1:0]  store_val_o,
    output logic              seq_clr_o,
    output logic              sw_smi_o
);
    reg_addr_e        sel;
    logic [7:0]       din_q, dout_q, msg1_q, msg2_q, wdctl_q, swirq_q;
    logic [REG_W-1:0] stat1_q, stat2_q, ctrl1_q, ctrl2_q;
    logic [REG_W-1:0] stat1_d, stat2_d;
    logic [CNT_W-1:0] timeout_q;
    logic             wr_count, wr_din, wr_dout, wr_stat1, wr_stat2, wr_ctrl1;
    logic             tmo_ok, run_ok_reload, run_ok_ctrl;

    assign sel      = reg_addr_e'(addr_i);
    assign wr_count = wr_i && (sel == A_COUNT);
    assign wr_din   = wr_i && (sel == A_DIN);
    assign wr_dout  = wr_i && (sel == A_DOUT);
    assign wr_stat1 = wr_i && (sel == A_STAT1);
    assign wr_stat2 = wr_i && (sel == A_STAT2);
    assign wr_ctrl1 = wr_i && (sel == A_CTRL1);

    // run conditions: reload uses current halt, control write the new one
    assign tmo_ok        = timeout_q > CNT_W'(1);
    assign run_ok_reload = tmo_ok && !ctrl1_q[C1_HALT];
    assign run_ok_ctrl   = tmo_ok && !wdata_i[C1_HALT];

    assign start_o     = (wr_count && run_ok_reload) || (wr_ctrl1 && run_ok_ctrl);
    assign store_o     = wr_count && !run_ok_reload;
    assign stop_o      = wr_ctrl1 && !run_ok_ctrl;
    assign store_val_o = wdata_i[CNT_W-1:0];
    assign seq_clr_o   = wr_count;
    assign sw_smi_o    = wr_din;
    assign timeout_o   = timeout_q;

    // status next-state: masked replace, then event bits OR in
    always_comb begin
        stat1_d = wr_stat1 ? (wdata_i & STAT1_MASK) : stat1_q;
        stat2_d = wr_stat2 ? (wdata_i & STAT2_MASK) : stat2_q;
        if (expire_i) stat1_d[S1_EXPIRED] = 1'b1;
        if (wr_din)   stat1_d[S1_SWSMI]   = 1'b1;
        if (wr_dout)  stat1_d[S1_DOUT]    = 1'b1;
        if (second_i) begin
            stat2_d[S2_SECOND] = 1'b1;
            stat2_d[S2_BOOT]   = 1'b1;
        end
    end

    // status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat1_q <= '0;
            stat2_q <= '0;
        end else begin
            stat1_q <= stat1_d;
            stat2_q <= stat2_d;
        end
    end

    // control 1: masked store with a sticky lock bit
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl1_q <= '0;
        else if (wr_ctrl1) ctrl1_q <= (wdata_i & CTRL1_MASK)
                                    | (ctrl1_q & (REG_W'(1) << C1_LOCK));
    end

    // plain storage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q     <= '0;
            dout_q    <= '0;
            msg1_q    <= '0;
            msg2_q    <= '0;
            wdctl_q   <= '0;
            swirq_q   <= SWIRQ_RST;
            ctrl2_q   <= CTRL2_RST;
            timeout_q <= CNT_W'(TIMEOUT_RST);
        end else if (wr_i) begin
            case (sel)
                A_DIN:     din_q     <= wdata_i[7:0];
                A_DOUT:    dout_q    <= wdata_i[7:0];
                A_MSG1:    msg1_q    <= wdata_i[7:0];
                A_MSG2:    msg2_q    <= wdata_i[7:0];
                A_WDCTL:   wdctl_q   <= wdata_i[7:0];
                A_SWIRQ:   swirq_q   <= wdata_i[7:0];
                A_CTRL2:   ctrl2_q   <= wdata_i;
                A_TIMEOUT: timeout_q <= wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        rdata_o = '0;
        case (sel)
            A_COUNT:   rdata_o[CNT_W-1:0] = cnt_i;
            A_DIN:     rdata_o[7:0]       = din_q;
            A_DOUT:    rdata_o[7:0]       = dout_q;
            A_STAT1:   rdata_o            = stat1_q;
            A_STAT2:   rdata_o            = stat2_q;
            A_CTRL1:   rdata_o            = ctrl1_q;
            A_CTRL2:   rdata_o            = ctrl2_q;
            A_MSG1:    rdata_o[7:0]       = msg1_q;
            A_MSG2:    rdata_o[7:0]       = msg2_q;
            A_WDCTL:   rdata_o[7:0]       = wdctl_q;
            A_TIMEOUT: rdata_o[CNT_W-1:0] = timeout_q;
            A_SWIRQ:   rdata_o[7:0]       = swirq_q;
            default:   rdata_o            = '0;
        endcase
    end

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl1_q[C1_LOCK] |=> ctrl1_q[C1_LOCK]);

    a_r3_second_status: assert property (@(posedge clk) disable iff (!rst_n)
        second_i |=> (stat2_q[S2_SECOND] && stat2_q[S2_BOOT]));
endmodule

// File: rtl/wdt_two_stage.sv
// Module: wdt_two_stage (top)
// Two-stage watchdog: prescaler, countdown and register file, with the SMI
// and reset-request pulses registered here. Assumes one register access per
// cycle and synchronous active-low reset.
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int TICK_CYCLES = 1000,
    parameter int CNT_W       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic              smi_en_i,
    input  logic              hold_strap_i,
    input  logic              reboot_block_i,
    output logic              smi_o,
    output logic              rst_req_o
);
    logic             tick, run, expire, second, fire_reset;
    logic             start, stop, store, seq_clr, sw_smi;
    logic [CNT_W-1:0] cnt, timeout, store_val;
    logic             smi_q, rst_q;

    wdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start),
        .run_i   (run),
        .tick_o  (tick)
    );

    wdt_countdown #(.CNT_W(CNT_W)) u_count (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick_i          (tick),
        .start_i         (start),
        .stop_i          (stop),
        .store_i         (store),
        .store_val_i     (store_val),
        .seq_clr_i       (seq_clr),
        .timeout_i       (timeout),
        .reset_allowed_i (!hold_strap_i && !reboot_block_i),
        .cnt_o           (cnt),
        .run_o           (run),
        .expire_o        (expire),
        .second_o        (second),
        .fire_reset_o    (fire_reset)
    );

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (reg_addr_i),
        .wr_i        (reg_wr_i),
        .wdata_i     (reg_wdata_i),
        .rdata_o     (reg_rdata_o),
        .cnt_i       (cnt),
        .expire_i    (expire),
        .second_i    (second),
        .timeout_o   (timeout),
        .start_o     (start),
        .stop_o      (stop),
        .store_o     (store),
        .store_val_o (store_val),
        .seq_clr_o   (seq_clr),
        .sw_smi_o    (sw_smi)
    );

    // output pulses: SMI from data-in or a non-reset enabled expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            smi_q <= sw_smi || (expire && !fire_reset && smi_en_i);
            rst_q <= fire_reset;
        end
    end

    assign smi_o     = smi_q;
    assign rst_req_o = rst_q;

    a_r4_reset_stops: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !run);

    a_r5_smi_source: assert property (@(posedge clk) disable iff (!rst_n)
        smi_o |-> ($past(sw_smi) || $past(smi_en_i)));
endmodule

// File: tb/test_wdt_two_stage.sv
`timescale 1ns/100ps
module test_wdt_two_stage;
    localparam int TICK = 4;
    localparam int CW   = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        smi_en = 1'b0, strap = 1'b0, rblock = 1'b1;
    logic        smi_o, rst_req_o;
    int          total = 0, bad = 0;

    always #2 clk = ~clk;

    wdt_two_stage #(.TICK_CYCLES(TICK), .CNT_W(CW)) i_wdt_two_stage (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .smi_en_i(smi_en),
        .hold_strap_i(strap), .reboot_block_i(rblock),
        .smi_o(smi_o), .rst_req_o(rst_req_o));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input int d);
        @(negedge clk);
        addr = 4'(a); wdata = 16'(d); wr = 1'b1;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input int exp);
        @(negedge clk);
        addr = 4'(a);
        #1 chk(tag, int'(rdata), exp);
    endtask

    // counts negedges until a pulse appears; n = 0 if none within limit
    task automatic wait_evt(input int limit, output int n, output int s, output int r);
        bit seen = 0;
        n = 0; s = 0; r = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (!seen && (smi_o || rst_req_o)) begin
                seen = 1; n = i; s = int'(smi_o); r = int'(rst_req_o);
            end
            if (seen) break;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // halt, program timeout, clear status, unhalt, then restart by reload
    task automatic arm(input int t);
        wr_reg(5, 1); wr_reg(10, t); wr_reg(3, 0); wr_reg(4, 0);
        wr_reg(5, 0); wr_reg(0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, s, r, v;
        do_reset();
        // R10 reset contents
        for (int a = 0; a < 16; a++) begin
            v = (a == 6) ? 8 : (a == 10) ? 4 : (a == 11) ? 3 : 0;
            rd_chk($sformatf("R10 addr %0d", a), a, v);
        end
        chk("R10 smi low", int'(smi_o), 0);
        chk("R10 rst_req low", int'(rst_req_o), 0);

        // R11 masked status writes
        wr_reg(3, 16'hFFFF); rd_chk("R11 stat1 mask", 3, 16'h0007);
        wr_reg(4, 16'hFFFF); rd_chk("R11 stat2 mask", 4, 16'h0003);
        wr_reg(3, 0);        rd_chk("R11 stat1 clear", 3, 0);
        wr_reg(4, 0);        rd_chk("R11 stat2 clear", 4, 0);

        // R12 plain registers
        wr_reg(6, 16'hBEEF);  rd_chk("R12 ctrl2", 6, 16'hBEEF);
        wr_reg(7, 16'h1234);  rd_chk("R12 msg1", 7, 16'h34);
        wr_reg(8, 16'hAB56);  rd_chk("R12 msg2", 8, 16'h56);
        wr_reg(9, 16'h7F9A);  rd_chk("R12 wdctl", 9, 16'h9A);
        wr_reg(11, 16'h0FC3); rd_chk("R12 swirq", 11, 16'hC3);
        wr_reg(10, 16'hFFFF); rd_chk("R12 timeout mask", 10, 16'h03FF);
        wr_reg(12, 16'hFFFF); rd_chk("R12 unused addr", 12, 0);
        wr_reg(5, 1); wr_reg(10, 4);

        // R9 data-in / data-out side effects (smi_en low, timer halted)
        wr_reg(3, 0);
        wr_reg(1, 16'h12A5);
        @(negedge clk); chk("R9 din smi pulse", int'(smi_o), 1);
        @(negedge clk); chk("R9 din smi one cycle", int'(smi_o), 0);
        rd_chk("R9 din value", 1, 16'hA5);
        rd_chk("R9 din status", 3, 16'h0002);
        wr_reg(2, 16'h345A);
        wait_evt(4, n, s, r); chk("R9 dout no smi", n, 0);
        rd_chk("R9 dout value", 2, 16'h5A);
        rd_chk("R9 dout status", 3, 16'h0006);

        // R1 timeout 0 and 1 never start; halt blocks too
        for (int t = 0; t < 2; t++) begin
            wr_reg(5, 1); wr_reg(10, t); wr_reg(3, 0);
            wr_reg(5, 0); wr_reg(0, 16'h0123 + t);
            wait_evt(40, n, s, r); chk($sformatf("R1 t=%0d no expiry", t), n, 0);
            rd_chk($sformatf("R1 t=%0d stored", t), 0, 16'h0123 + t);
            rd_chk($sformatf("R1 t=%0d status", t), 3, 0);
        end
        wr_reg(5, 1); wr_reg(10, 5); wr_reg(0, 7);
        wait_evt(40, n, s, r); chk("R1 halted no expiry", n, 0);
        rd_chk("R1 halted count frozen", 0, 7);

        // R2 R3 R5 sweep over timeouts, reboot blocked, SMI enabled
        smi_en = 1'b1; rblock = 1'b1; strap = 1'b0;
        for (int t = 2; t <= 6; t++) begin
            arm(t);
            wait_evt(200, n, s, r);
            chk($sformatf("R2 t=%0d first expiry cycle", t), n, t * TICK + 1);
            chk($sformatf("R5 t=%0d first smi", t), s, 1);
            wait_evt(200, n, s, r);
            chk($sformatf("R2 t=%0d second expiry cycle", t), n, t * TICK);
            chk($sformatf("R4 t=%0d blocked gives smi", t), s * 2 + r, 2);
            rd_chk($sformatf("R2 t=%0d stat1", t), 3, 1);
            rd_chk($sformatf("R3 t=%0d stat2", t), 4, 3);
        end

        // R2 R7 remaining ticks after a control-1 start
        wr_reg(5, 1); wr_reg(10, 6);
        wr_reg(5, 0);
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk); addr = 4'd0;
            #1 chk($sformatf("R2 remaining at %0d", i), int'(rdata), 6 - (i - 1) / TICK);
        end

        // R7 halt freezes count
        wr_reg(5, 1); wr_reg(10, 5);
        wr_reg(5, 0);
        repeat (10) @(posedge clk);
        wr_reg(5, 1);
        rd_chk("R7 halt frozen", 0, 3);
        repeat (20) @(negedge clk);
        rd_chk("R7 halt stays frozen", 0, 3);
        wr_reg(5, 16'hFFFC); rd_chk("R7 ctrl1 mask", 5, 0);
        wr_reg(5, 1);

        // R4 reset path
        rblock = 1'b0; strap = 1'b0;
        arm(2);
        wait_evt(50, n, s, r);
        chk("R4 first is smi", n * 4 + s * 2 + r, 9 * 4 + 2);
        wait_evt(50, n, s, r);
        chk("R4 second is reset", n * 4 + s * 2 + r, 8 * 4 + 1);
        rd_chk("R4 count zero", 0, 0);
        wait_evt(30, n, s, r); chk("R4 stopped", n, 0);
        rd_chk("R4 still zero", 0, 0);
        rd_chk("R3 stat2 on reset", 4, 3);
        strap = 1'b1;
        arm(2);
        wait_evt(50, n, s, r);
        wait_evt(50, n, s, r);
        chk("R4 strap holds reset", n * 4 + s * 2 + r, 8 * 4 + 2);
        strap = 1'b0;

        // R5 no SMI when disabled, status still set
        smi_en = 1'b0; rblock = 1'b1;
        arm(2);
        wait_evt(12, n, s, r); chk("R5 disabled no smi", n, 0);
        rd_chk("R5 expiry status", 3, 1);
        wr_reg(5, 1);

        // R6 reload between expiries clears the pair
        smi_en = 1'b1; rblock = 1'b0;
        arm(3);
        wait_evt(100, n, s, r); chk("R6 first expiry", n, 13);
        wr_reg(0, 0);
        wait_evt(100, n, s, r);
        chk("R6 after reload still first", n * 4 + s * 2 + r, 13 * 4 + 2);
        rd_chk("R6 stat2 clear", 4, 0);
        wr_reg(5, 1);
        wr_reg(0, 16'hFFFF); rd_chk("R6 stored masked", 0, 16'h03FF);

        // R8 lock bit
        wr_reg(5, 3);      rd_chk("R8 lock set", 5, 3);
        wr_reg(5, 0);      rd_chk("R8 lock kept", 5, 2);
        wr_reg(5, 16'hFFFF); rd_chk("R8 ctrl1 masked", 5, 3);
        do_reset();
        rd_chk("R8 reset clears lock", 5, 0);
        rd_chk("R10 count after reset", 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule